// File: doc/BRIEF.md
# Scanline Table Transfer Channel

This block runs one channel of a scanline-driven transfer engine. When a frame starts, it walks a table in memory. Each table entry is a line-counter byte whose top bit asks for repetition. When the channel is set to indirect addressing, the entry also carries a 16-bit pointer to the data. On every line strobe, the channel may issue a short burst of single-byte move requests. Each request pairs a 24-bit memory address with a 16-bit register address in a fixed page. The pattern of register addresses comes from a 3-bit transfer mode.

The block has two request ports, each with a single-cycle acknowledge. The table read port fetches entry bytes. The move port hands each byte move to the surrounding bus logic, which performs the move, filters it, and arbitrates between channels. A separate input tells the channel whether it is the last active channel on the current line. This input changes how a terminating entry is fetched in indirect mode. The channel configuration is treated as static for the whole frame.

Top module: `hdma_chan_seq`

## Requirements
- R1: After reset the channel is idle (`busy`=0), inactive (`done`=1) and raises no request.
- R2: On `frame_init` the channel reads one byte at {`cfg_src_bank`, `cfg_tbl_start`} into the line register and steps the table pointer by one. Every table read steps the 16-bit table pointer by +1 with wrap. If the initial byte is 0x00, `done` goes to 1 and no further table byte is read.
- R3: In indirect mode, after a non-zero initial byte, init reads the low pointer byte and then the high pointer byte from the next two table addresses. `busy` then stays high for `IND_STALL` more cycles. With single-cycle acknowledges, `busy` is high for 3+`IND_STALL` cycles in indirect mode and for 1 cycle in direct mode.
- R4: The transfer mode selects both the burst length and the per-byte offset. Mode 0 gives 1 byte with offset 0. Mode 1 gives 2 bytes with offsets 0,1. Modes 2 and 6 give 2 bytes with offsets 0,0. Modes 3 and 7 give 4 bytes with offsets 0,0,1,1. Mode 4 gives 4 bytes with offsets 0,1,2,3. Mode 5 gives 4 bytes with offsets 0,1,0,1. Byte i is sent to register address {0x21, `cfg_dest`+offset[i] mod 256}.
- R5: The memory address of each move depends on the addressing mode. In indirect mode it is {`cfg_ind_bank`, pointer}. In direct mode it is {`cfg_src_bank`, table pointer}. After each acknowledged move, that 16-bit pointer steps by -1 when `cfg_decrement`=1 and by +1 otherwise, and the bank never changes.
- R6: `mv_b_to_a` equals `cfg_b_to_a` on every move request.
- R7: If bit 7 of the line register is set, every line issues a burst. If bit 7 is clear, only the first line after a load issues a burst. Each line strobe decrements the 7-bit count.
- R8: When a line strobe brings the 7-bit count to zero, the channel reads the next line byte at the current table pointer. In indirect mode it also reads a fresh pointer, low byte first, from the following two addresses. A reloaded 0x00 sets `done`.
- R9: Suppose a reloaded byte in indirect mode is 0x00 and `last_chan` was 1 at that line strobe. Then only one more table byte is read. That byte becomes the pointer's high byte, and the low byte is 0x00. If `last_chan` was 0, two bytes are read as usual.
- R10: While `done`=1, line strobes cause no request of either kind until the next `frame_init`.
- R11: A raised request keeps its address stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src_bank | input | 8 | Bank of the table (and of direct data) |
| cfg_tbl_start | input | 16 | Table start address within the bank |
| cfg_ind_bank | input | 8 | Bank used for indirect data |
| cfg_dest | input | 8 | Low byte of the base register address |
| cfg_mode | input | 3 | Transfer mode (burst pattern) |
| cfg_b_to_a | input | 1 | Move direction flag passed to the mover |
| cfg_indirect | input | 1 | 1 = table entries carry a data pointer |
| cfg_decrement | input | 1 | 1 = data pointer steps down |
| frame_init | input | 1 | Start-of-frame strobe, restarts the table walk |
| line_go | input | 1 | Per-line strobe |
| last_chan | input | 1 | This channel is the last active one on the line |
| tbl_req | output | 1 | Table byte read request |
| tbl_addr | output | 24 | Table byte address |
| tbl_ack | input | 1 | Table read accepted, data valid |
| tbl_data | input | 8 | Table byte |
| mv_req | output | 1 | Byte move request |
| mv_a_addr | output | 24 | Memory-side address of the move |
| mv_b_addr | output | 16 | Register-side address of the move |
| mv_b_to_a | output | 1 | Direction of the move |
| mv_ack | input | 1 | Move accepted |
| busy | output | 1 | Channel is fetching, moving or stalling |
| done | output | 1 | Channel finished (or never started) |

## Verification
All eight transfer modes are swept in direct mode, with both pointer directions and a table start placed so that the pointer wraps. A register base of 0xFE is used so that offset wrap shows up in the register address. Acknowledges alternate between immediate and delayed. This separates the burst-length and offset tables from the stepping and wrap logic, and the delayed acknowledges exercise request holding. A multi-line table mixes a non-repeating count of 3 with a repeating count of 3, which tells the repeat-bit rule apart from the count rule. Indirect tables with a terminating entry are run with the last-channel input both high and low, which isolates the single-byte fetch. A zero first entry and the init busy length close out the init path.

// File: rtl/hdma_chan_seq.sv
module hdma_chan_seq #(
  parameter int          IND_STALL = 3,
  parameter logic [7:0]  B_PAGE    = 8'h21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cfg_src_bank,
  input  logic [15:0] cfg_tbl_start,
  input  logic [7:0]  cfg_ind_bank,
  input  logic [7:0]  cfg_dest,
  input  logic [2:0]  cfg_mode,
  input  logic        cfg_b_to_a,
  input  logic        cfg_indirect,
  input  logic        cfg_decrement,
  input  logic        frame_init,
  input  logic        line_go,
  input  logic        last_chan,
  output logic        tbl_req,
  output logic [23:0] tbl_addr,
  input  logic        tbl_ack,
  input  logic [7:0]  tbl_data,
  output logic        mv_req,
  output logic [23:0] mv_a_addr,
  output logic [15:0] mv_b_addr,
  output logic        mv_b_to_a,
  input  logic        mv_ack,
  output logic        busy,
  output logic        done
);
  localparam int SW = (IND_STALL > 1) ? $clog2(IND_STALL) : 1;

  typedef enum logic [2:0] {S_IDLE, S_LC, S_LO, S_HI, S_WAIT, S_MOVE} st_t;

  st_t         st;
  logic [15:0] tbl_ptr, ind_ptr;
  logic [7:0]  lc, lo_q;
  logic [1:0]  idx;
  logic [SW-1:0] stall;
  logic        fin, is_init, last_q, xfer_pend;

  logic [2:0]  nbytes;
  logic [1:0]  off;
  always_comb begin
    case (cfg_mode)
      3'd0:        begin nbytes = 3'd1; off = 2'd0; end
      3'd1:        begin nbytes = 3'd2; off = {1'b0, idx[0]}; end
      3'd2, 3'd6:  begin nbytes = 3'd2; off = 2'd0; end
      3'd4:        begin nbytes = 3'd4; off = idx; end
      3'd5:        begin nbytes = 3'd4; off = {1'b0, idx[0]}; end
      default:     begin nbytes = 3'd4; off = {1'b0, idx[1]}; end
    endcase
  end

  wire        last_byte = (idx == 2'(nbytes - 3'd1));
  wire [6:0]  cnt_dec   = lc[6:0] - 7'd1;
  wire [15:0] step      = cfg_decrement ? 16'hFFFF : 16'h0001;

  assign tbl_req   = (st == S_LC) || (st == S_LO) || (st == S_HI);
  assign tbl_addr  = {cfg_src_bank, tbl_ptr};
  assign mv_req    = (st == S_MOVE);
  assign mv_a_addr = cfg_indirect ? {cfg_ind_bank, ind_ptr} : {cfg_src_bank, tbl_ptr};
  assign mv_b_addr = {B_PAGE, cfg_dest + {6'd0, off}};
  assign mv_b_to_a = cfg_b_to_a;
  assign busy      = (st != S_IDLE);
  assign done      = fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tbl_ptr <= '0; ind_ptr <= '0; lc <= '0; lo_q <= '0;
      idx <= '0; stall <= '0; fin <= 1'b1; is_init <= 1'b0; last_q <= 1'b0;
      xfer_pend <= 1'b0;
    end else if (frame_init) begin
      st <= S_LC; tbl_ptr <= cfg_tbl_start; fin <= 1'b0; is_init <= 1'b1;
      last_q <= 1'b0; idx <= '0;
    end else begin
      case (st)
        S_IDLE: if (line_go && !fin) begin
          last_q  <= last_chan;
          is_init <= 1'b0;
          if (xfer_pend) begin
            st  <= S_MOVE;
            idx <= '0;
          end else begin
            lc[6:0]   <= cnt_dec;
            xfer_pend <= lc[7];
            if (cnt_dec == 7'd0) st <= S_LC;
          end
        end
        S_LC: if (tbl_ack) begin
          lc        <= tbl_data;
          tbl_ptr   <= tbl_ptr + 16'd1;
          xfer_pend <= 1'b1;
          if (tbl_data == 8'h00 && (is_init || !cfg_indirect)) begin
            fin <= 1'b1;
            st  <= S_IDLE;
          end else if (cfg_indirect) begin
            if (tbl_data == 8'h00 && last_q) begin
              lo_q <= 8'h00;
              st   <= S_HI;
            end else begin
              st <= S_LO;
            end
          end else begin
            st <= S_IDLE;
          end
        end
        S_LO: if (tbl_ack) begin
          lo_q    <= tbl_data;
          tbl_ptr <= tbl_ptr + 16'd1;
          st      <= S_HI;
        end
        S_HI: if (tbl_ack) begin
          ind_ptr <= {tbl_data, lo_q};
          tbl_ptr <= tbl_ptr + 16'd1;
          if (lc == 8'h00) fin <= 1'b1;
          if (is_init && IND_STALL > 0) begin
            st    <= S_WAIT;
            stall <= SW'(IND_STALL - 1);
          end else begin
            st <= S_IDLE;
          end
        end
        S_WAIT: begin
          if (stall == '0) st <= S_IDLE;
          else             stall <= stall - 1'b1;
        end
        S_MOVE: if (mv_ack) begin
          if (cfg_indirect) ind_ptr <= ind_ptr + step;
          else              tbl_ptr <= tbl_ptr + step;
          idx <= idx + 2'd1;
          if (last_byte) begin
            lc[6:0]   <= cnt_dec;
            xfer_pend <= lc[7];
            st        <= (cnt_dec == 7'd0) ? S_LC : S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_TBL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req && !tbl_ack && !frame_init |=> tbl_req && $stable(tbl_addr)); // R11

  AST_MV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req && !mv_ack && !frame_init && $stable(cfg_indirect) |=>
      mv_req && $stable(mv_a_addr) && $stable(mv_b_addr)); // R11

  AST_TBL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req && tbl_ack && !frame_init |=>
      tbl_addr[15:0] == $past(tbl_addr[15:0]) + 16'd1); // R2

  AST_MV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req && mv_ack && !frame_init && $stable(cfg_decrement) && $stable(cfg_indirect) |=>
      mv_a_addr[15:0] == $past(mv_a_addr[15:0]) + (cfg_decrement ? 16'hFFFF : 16'h0001)); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done && !frame_init |=> !tbl_req && !mv_req); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
endmodule

// File: tb/hdma_chan_seq_tb.sv
module hdma_chan_seq_tb;
  localparam int STALL = 3;

  logic clk = 0, rst_n = 0;
  logic [7:0]  cfg_src_bank = 0, cfg_ind_bank = 0, cfg_dest = 0;
  logic [15:0] cfg_tbl_start = 0;
  logic [2:0]  cfg_mode = 0;
  logic cfg_b_to_a = 0, cfg_indirect = 0, cfg_decrement = 0;
  logic frame_init = 0, line_go = 0, last_chan = 0;
  logic tbl_req, mv_req, mv_b_to_a, busy, done;
  logic [23:0] tbl_addr, mv_a_addr;
  logic [15:0] mv_b_addr;
  logic tbl_ack, mv_ack;
  logic [7:0] tbl_data;

  hdma_chan_seq #(.IND_STALL(STALL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_src_bank(cfg_src_bank), .cfg_tbl_start(cfg_tbl_start),
    .cfg_ind_bank(cfg_ind_bank), .cfg_dest(cfg_dest), .cfg_mode(cfg_mode),
    .cfg_b_to_a(cfg_b_to_a), .cfg_indirect(cfg_indirect), .cfg_decrement(cfg_decrement),
    .frame_init(frame_init), .line_go(line_go), .last_chan(last_chan),
    .tbl_req(tbl_req), .tbl_addr(tbl_addr), .tbl_ack(tbl_ack), .tbl_data(tbl_data),
    .mv_req(mv_req), .mv_a_addr(mv_a_addr), .mv_b_addr(mv_b_addr), .mv_b_to_a(mv_b_to_a),
    .mv_ack(mv_ack), .busy(busy), .done(done));

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  logic [23:0] et_a [16];
  logic [7:0]  et_d [16];
  logic [23:0] ec_a [16];
  logic [15:0] ec_b [16];
  int nt, nc, it, ic;
  logic slow = 0, tog = 0, exp_dir = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clr_exp();
    nt = 0; nc = 0; it = 0; ic = 0;
  endtask

  task automatic push_t(input logic [23:0] a, input logic [7:0] d);
    et_a[nt] = a; et_d[nt] = d; nt++;
  endtask

  task automatic push_c(input logic [23:0] a, input logic [15:0] b);
    ec_a[nc] = a; ec_b[nc] = b; nc++;
  endtask

  task automatic pulse(input bit is_frame, output int nb);
    @(negedge clk);
    if (is_frame) frame_init = 1; else line_go = 1;
    @(negedge clk);
    frame_init = 0; line_go = 0; nb = 0;
    while (busy) begin nb++; @(negedge clk); end
  endtask

  task automatic counts(input string tag);
    check(it == nt, {tag, " table read count"}, it, nt);
    check(ic == nc, {tag, " move count"}, ic, nc);
  endtask

  function automatic int nb_of(input int m);
    case (m)
      0: return 1;
      1, 2, 6: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [7:0] off_of(input int m, input int i);
    case (m)
      1, 4: return 8'(i);
      3, 7: return 8'(i / 2);
      5: return 8'(i % 2);
      default: return 8'd0;
    endcase
  endfunction

  initial begin
    tbl_ack = 0; mv_ack = 0; tbl_data = 0;
    forever begin
      @(negedge clk);
      tog = ~tog;
      if (tbl_req && (!slow || tog)) begin
        if (it < nt) begin
          check(tbl_addr == et_a[it], "R2/R8 table read address", tbl_addr, et_a[it]);
          tbl_data = et_d[it];
        end else begin
          check(0, "R10 unexpected table read", tbl_addr, 0);
          tbl_data = 0;
        end
        it++; tbl_ack = 1;
      end else tbl_ack = 0;
      if (mv_req && (!slow || tog)) begin
        if (ic < nc) begin
          check(mv_a_addr == ec_a[ic], "R5 move memory address", mv_a_addr, ec_a[ic]);
          check(mv_b_addr == ec_b[ic], "R4 move register address", mv_b_addr, ec_b[ic]);
          check(mv_b_to_a == exp_dir, "R6 move direction", mv_b_to_a, exp_dir);
        end else check(0, "R10 unexpected move", mv_a_addr, 0);
        ic++; mv_ack = 1;
      end else mv_ack = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int nb;
    logic [15:0] p, ip;
    clr_exp();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(done == 1, "R1 done after reset", done, 1);
    check(tbl_req == 0 && mv_req == 0, "R1 no request after reset", {tbl_req, mv_req}, 0);
    pulse(0, nb);
    counts("R10 line strobe before init");

    // Direct sweep: all modes, both directions, wrap of pointer and offset
    cfg_src_bank = 8'h7E; cfg_dest = 8'hFE; cfg_indirect = 0;
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 2; d++) begin
        cfg_mode = 3'(m); cfg_decrement = d[0]; cfg_b_to_a = (m % 3 == 0);
        exp_dir = cfg_b_to_a; slow = m[1];
        cfg_tbl_start = d ? 16'h0000 : 16'hFFFE;
        clr_exp();
        push_t({8'h7E, cfg_tbl_start}, 8'h01);
        pulse(1, nb);
        counts("R2 direct init");
        check(done == 0, "R2 active after init", done, 0);
        clr_exp();
        p = cfg_tbl_start + 16'd1;
        for (int i = 0; i < nb_of(m); i++) begin
          push_c({8'h7E, p}, {8'h21, 8'hFE + off_of(m, i)});
          p = d ? p - 16'd1 : p + 16'd1;
        end
        push_t({8'h7E, p}, 8'h00);
        pulse(0, nb);
        counts("R4 burst then R8 reload");
        check(done == 1, "R8 reloaded zero ends channel", done, 1);
        clr_exp();
        pulse(0, nb);
        counts("R10 strobe after done");
      end
    end

    // Repeat bit versus plain count
    slow = 0; cfg_mode = 0; cfg_decrement = 0; cfg_b_to_a = 0; exp_dir = 0;
    cfg_tbl_start = 16'h0200; cfg_dest = 8'h10;
    clr_exp(); push_t(24'h7E0200, 8'h03);
    pulse(1, nb);
    check(nb == 1, "R3 direct init busy length", nb, 1);
    clr_exp(); push_c(24'h7E0201, 16'h2110); pulse(0, nb); counts("R7 first line of plain entry");
    clr_exp(); pulse(0, nb); counts("R7 second line no burst");
    clr_exp(); push_t(24'h7E0202, 8'h83); pulse(0, nb); counts("R7 third line reload");
    for (int l = 0; l < 3; l++) begin
      clr_exp(); push_c({8'h7E, 16'h0203 + 16'(l)}, 16'h2110);
      if (l == 2) push_t(24'h7E0206, 8'h00);
      pulse(0, nb); counts("R7 repeating line burst");
    end
    check(done == 1, "R8 done after terminator", done, 1);

    // Indirect tables, terminator on last and non-last channel
    for (int la = 1; la >= 0; la--) begin
      cfg_indirect = 1; cfg_mode = 1; cfg_decrement = (la == 0); cfg_src_bank = 8'h12;
      cfg_ind_bank = 8'h34; cfg_dest = 8'h18; cfg_tbl_start = 16'h0100; last_chan = la[0];
      cfg_b_to_a = la[0]; exp_dir = la[0]; slow = 0;
      clr_exp();
      push_t(24'h120100, 8'h82); push_t(24'h120101, 8'h00); push_t(24'h120102, 8'h50);
      pulse(1, nb);
      counts("R3 indirect init");
      check(nb == 3 + STALL, "R3 indirect init busy length", nb, 3 + STALL);
      slow = 1;
      ip = 16'h5000;
      for (int l = 0; l < 3; l++) begin
        clr_exp();
        for (int i = 0; i < 2; i++) begin
          push_c({8'h34, ip}, {8'h21, 8'h18 + 8'(i)});
          ip = cfg_decrement ? ip - 16'd1 : ip + 16'd1;
        end
        if (l == 1) begin
          push_t(24'h120103, 8'h01); push_t(24'h120104, 8'h10); push_t(24'h120105, 8'h60);
          ip = 16'h6010;
        end
        if (l == 2) begin
          push_t(24'h120106, 8'h00); push_t(24'h120107, 8'h77);
          if (la == 0) push_t(24'h120108, 8'h66);
        end
        pulse(0, nb);
        counts(la ? "R9 indirect line, last channel" : "R8 indirect line, not last");
      end
      check(done == 1, "R9 done after indirect terminator", done, 1);
      clr_exp(); pulse(0, nb); counts("R10 strobe after indirect done");
    end

    // Zero first entry in indirect mode: one read only
    slow = 0; clr_exp(); push_t(24'h120100, 8'h00);
    pulse(1, nb);
    counts("R2 zero first entry");
    check(done == 1, "R2 zero first entry ends channel", done, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule